// File: doc/BRIEF.md
# Prescaled Programmable Baud Tick Generator

This block turns a reference clock into the timing strobes a serial transmitter and receiver need. It produces a one-cycle enable at sixteen times the serial bit rate, plus a bit-rate tick on every sixteenth of those enables. The rate is set by a 16-bit divisor and a prescale select. The divisor is written one byte at a time through a small register port. The prescale select picks a divide-by-1 or divide-by-4 stage that sits in front of the divisor. The enable period, counted in reference clock cycles, is the prescale ratio times the divisor. A divisor of zero acts as one. Each serial channel instantiates its own copy.

The divide counter is controlled by a two-state machine. `ST_WAIT` means a reload is pending. `ST_RUN` means the counter is counting prescaled ticks down. Reset enters `ST_WAIT`. The transition `WAIT->RUN` happens on the next prescaled tick: it loads the counter with the current divisor and clears the bit-rate counter. `RUN->RUN` decrements the counter on each prescaled tick, or fires a pulse and reloads when the count is 1. `RUN->WAIT` happens on any divisor byte write, so the old partial count is discarded.

Top module: `baud_tick_gen`

## Requirements
- R1: With `presc_x4` = 0, the spacing between consecutive `os_tick` pulses is max(D,1) clock cycles, where D = {high byte, low byte}.
- R2: With `presc_x4` = 1, the spacing between consecutive `os_tick` pulses is 4*max(D,1) clock cycles.
- R3: A write with `wr_addr` = 0 sets divisor bits 7:0, and a write with `wr_addr` = 1 sets bits 15:8. Both bytes are captured on the clock edge where `wr_en` is high.
- R4: A divisor value of 0 behaves exactly like a divisor of 1.
- R5: `os_tick` is a single-cycle pulse whenever the period (ratio times divisor) exceeds 1. With a period of 1 it stays high on every cycle.
- R6: With `presc_x4` = 0, the first `os_tick` after a divisor write comes no later than D+4 clock edges after the edge that captured the write, whatever count the old divisor had reached.
- R7: `bit_tick` is a single-cycle pulse on every 16th `os_tick`, so its spacing is 16 times the `os_tick` spacing.
- R8: A divisor write clears the bit-rate count. With `presc_x4` = 0, the first `bit_tick` after the write comes between 16*D and 16*D+6 edges after the capturing edge.
- R9: During and directly after reset, `os_tick` and `bit_tick` are low. Both divisor bytes reset to 0, so with `presc_x4` = 0 the pulse spacing after reset is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_x4 | input | 1 | 0: prescale by 1, 1: prescale by 4 |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_addr | input | 1 | 0: low byte, 1: high byte |
| wr_data | input | 8 | Byte to write |
| os_tick | output | 1 | One-cycle enable at 16x bit rate |
| bit_tick | output | 1 | One-cycle enable at bit rate |

## Verification
The main division is swept over divisors 0, 1, 2, 3, 5, 16 and 256, each with both prescale settings, and the measured `os_tick` and `bit_tick` spacings are compared with ratio times divisor. Divisor 0 against divisor 1 shows whether the zero case is clamped. Divisor 256, written as high byte 1 and low byte 0, shows whether the bytes land in the right lanes. Divisors 1 and 2 separate a continuous enable from a one-cycle pulse. A separate pattern writes a short divisor while a long count of 200 is under way. That case shows whether the counter and the bit-rate count are restarted or allowed to run out their old counts.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/bt_prescale.sv
module bt_prescale #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_slow,
    output logic pre_tick
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign pre_tick = sel_slow ? (cnt_q == LAST) : 1'b1;

    // two slow ticks are never adjacent
    assert_div4_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_slow && pre_tick) |=> !(sel_slow && pre_tick));
endmodule

// File: rtl/bt_divreg.sv
module bt_divreg #(
    parameter int DIV_W = 16,
    parameter int AW    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    output logic [DIV_W-1:0] div_eff,
    output logic             reload_req
);
    localparam int NB = DIV_W / 8;

    logic [DIV_W-1:0] raw;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                 byte_q <= 8'h00;
            else if (wr_en && (wr_addr == AW'(g)))      byte_q <= wr_data;
        end
        assign raw[g*8 +: 8] = byte_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reload_req <= 1'b0;
        else        reload_req <= wr_en;
    end

    assign div_eff = (raw == '0) ? DIV_W'(1) : raw;
endmodule

// File: rtl/bt_divider.sv
module bt_divider
    import baud_tick_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick,
    input  logic             reload_req,
    input  logic [DIV_W-1:0] div_i,
    output logic             os_q,
    output logic             load_o
);
    div_state_e       st_q, st_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             fire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_WAIT;
            cnt_q <= DIV_W'(1);
            os_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            os_q  <= fire;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        fire   = 1'b0;
        load_o = 1'b0;
        unique case (st_q)
            ST_WAIT: begin
                if (!reload_req && pre_tick) begin
                    cnt_d  = div_i;
                    st_d   = ST_RUN;
                    load_o = 1'b1;
                end
            end
            ST_RUN: begin
                if (reload_req) begin
                    st_d = ST_WAIT;
                end else if (pre_tick) begin
                    if (cnt_q == DIV_W'(1)) begin
                        fire  = 1'b1;
                        cnt_d = div_i;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: st_d = ST_WAIT;
        endcase
    end

    assert_cnt_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cnt_q != '0));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (os_q && div_i > DIV_W'(1)) |=> !os_q);

    assert_write_stops_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> (st_q == ST_WAIT));
endmodule

// File: rtl/bt_bitcnt.sv
module bt_bitcnt #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic os_tick,
    output logic bit_q
);
    localparam int CW = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= 1'b0;
        end else begin
            bit_q <= !clear && os_tick && (cnt_q == LAST);
            if (clear)        cnt_q <= '0;
            else if (os_tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assert_bit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q |=> !bit_q);

    assert_bit_follows_os_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_q) |-> $past(os_tick));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int DIV_W     = 16,
    parameter int PRE_RATIO = 4,
    parameter int OS_RATIO  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       presc_x4,
    input  logic       wr_en,
    input  logic [0:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       os_tick,
    output logic       bit_tick
);
    logic             pre_tick;
    logic             reload_req;
    logic             load_evt;
    logic [DIV_W-1:0] div_eff;

    bt_prescale #(.RATIO(PRE_RATIO)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel_slow(presc_x4), .pre_tick(pre_tick)
    );

    bt_divreg #(.DIV_W(DIV_W), .AW(1)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_eff(div_eff), .reload_req(reload_req)
    );

    bt_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .reload_req(reload_req),
        .div_i(div_eff), .os_q(os_tick), .load_o(load_evt)
    );

    bt_bitcnt #(.RATIO(OS_RATIO)) u_bit (
        .clk(clk), .rst_n(rst_n), .clear(load_evt), .os_tick(os_tick),
        .bit_q(bit_tick)
    );

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!os_tick && !bit_tick));
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presc_x4 = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       os_tick, bit_tick;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    baud_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .presc_x4(presc_x4), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .os_tick(os_tick), .bit_tick(bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic a, input logic [7:0] d, output int wcyc);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wcyc = cyc;
    endtask

    task automatic next_os(output int c);
        do @(negedge clk); while (!os_tick);
        c = cyc;
    endtask

    task automatic next_bit(output int c);
        do @(negedge clk); while (!bit_tick);
        c = cyc;
    endtask

    initial begin
        int dl[7] = '{0, 1, 2, 3, 5, 16, 256};
        int t0, t1, wc;
        repeat (4) @(negedge clk);
        // R9: quiet during reset
        check(!os_tick && !bit_tick, "R9", int'(os_tick) + int'(bit_tick), 0);
        rst_n = 1'b1;
        next_os(t0);
        next_os(t1);
        // R9 / R4: reset divisor 0 gives spacing 1
        check(t1 - t0 == 1, "R9", t1 - t0, 1);

        for (int p = 0; p < 2; p++) begin
            presc_x4 = p[0];
            for (int i = 0; i < 7; i++) begin
                int d, eff, per;
                d = dl[i];
                eff = (d == 0) ? 1 : d;
                per = eff * ((p == 1) ? 4 : 1);
                write_byte(1'b0, 8'(d), wc);          // R3 low byte
                write_byte(1'b1, 8'(d >> 8), wc);     // R3 high byte
                next_os(t0);
                next_os(t0);
                next_os(t1);
                if (p == 0) check(t1 - t0 == per, (d == 0) ? "R4" : (d == 256) ? "R3" : "R1", t1 - t0, per);
                else        check(t1 - t0 == per, (d == 0) ? "R4" : "R2", t1 - t0, per);
                if (per > 1) begin
                    @(negedge clk);
                    check(!os_tick, "R5", int'(os_tick), 0);
                end
                next_bit(t0);
                next_bit(t1);
                check(t1 - t0 == 16 * per, "R7", t1 - t0, 16 * per);
                @(negedge clk);
                check(!bit_tick, "R7", int'(bit_tick), 0);
            end
        end

        // R6 / R8: short divisor written during a long count
        presc_x4 = 1'b0;
        write_byte(1'b1, 8'h00, wc);
        write_byte(1'b0, 8'd200, wc);
        next_os(t0);
        next_os(t0);
        repeat (3) @(negedge clk);
        write_byte(1'b0, 8'd4, wc);
        next_os(t1);
        check(t1 - wc <= 8 && t1 - wc >= 1, "R6", t1 - wc, 6);
        next_bit(t1);
        check(t1 - wc >= 64 && t1 - wc <= 70, "R8", t1 - wc, 67);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule